// File: doc/BRIEF.md
# Asynchronous Serial Port, 8-Bit Frame Mode

This block is a byte-wide asynchronous serial port. Software sets it up through an 8-bit control register and moves data through a single buffer address. A write to the buffer starts a transmit. The `rx_data` output holds the last byte that was accepted. Only the framing with one start bit, eight data bits sent LSB first and one stop bit has a datapath. The other three values of the mode field can be written and read back, but they leave both directions idle.

Bit timing comes from an external timer, which delivers one-cycle overflow pulses on `ovf_tick`. One bit lasts a fixed number of these pulses (32 by default). A prescaler turns the pulses into a 16x oversampling tick.

The transmitter state machine has four states:
- `TX_IDLE` goes to `TX_START` on an accepted buffer write.
- `TX_START` goes to `TX_DATA` at the end of the start bit.
- `TX_DATA` goes to `TX_STOP` at the end of the eighth bit.
- `TX_STOP` goes back to `TX_IDLE` at the end of the stop bit, and sets the transmit-done flag.

The receiver state machine also has four states:
- `RX_IDLE` goes to `RX_START` on a falling edge of the line, but only while reception is allowed.
- `RX_START` goes back to `RX_IDLE` if the majority vote at mid-bit reads 1, which is a false start. Otherwise it goes to `RX_DATA` at the end of the bit.
- `RX_DATA` goes to `RX_STOP` after eight bits.
- `RX_STOP` goes to `RX_IDLE` at mid-stop, where it accepts or discards the byte.

Both done flags stay set until software writes the control register.

Top module: `sp_serial_m1`

## Requirements
- R1: After reset `ctrl_q` is 00h, `rx_data` is 00h and `txd` is high.
- R2: Control bits 7:6 form the mode field, and only the value 01 enables the datapath. In any other mode a buffer write sends nothing and a frame on `rxd` is not received.
- R3: In mode 01 a buffer write while the transmitter is idle drives `txd` low from the next cycle. The frame is a start bit, the 8 data bits LSB first, then a high stop bit, and each bit lasts 32 `ovf_tick` pulses.
- R4: The transmit-done flag (control bit 1) is set by hardware at the end of the stop bit. It stays set until software writes the control register.
- R5: The bit period follows the rate of `ovf_tick`. At one pulse every two cycles, a bit lasts 64 cycles in both directions.
- R6: With mode 01 and the receive enable (control bit 4) set, a valid frame on `rxd` loads `rx_data` with its byte. It also sets the receive-done flag (control bit 0) before the stop bit ends. The control value 50h gives this setup.
- R7: A received frame is discarded if the receive-done flag is already set, or if its stop bit samples as 0. In that case `rx_data` and the flag keep their values.
- R8: While the receive enable is 0, falling edges on `rxd` are ignored and no byte is received.
- R9: If the line is no longer low at the middle of the start bit, the receiver treats it as a false start. It returns to idle without setting a flag, and a following valid frame is received normally.
- R10: Each received bit is the majority of three 16x samples around mid-bit, so a one-cycle glitch at mid-bit does not change the byte.
- R11: A buffer write while a transmit is in progress is ignored. No second frame follows the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_tick | input | 1 | One-cycle timer overflow pulse |
| ctrl_wr | input | 1 | Write `wdata` to the control register |
| buf_wr | input | 1 | Write `wdata` to the transmit buffer |
| wdata | input | 8 | Write data |
| rxd | input | 1 | Serial receive line |
| ctrl_q | output | 8 | Control register contents |
| rx_data | output | 8 | Last accepted received byte |
| txd | output | 1 | Serial transmit line |

## Verification
The bench goes after the following corner cases, and each one names a wrong design it would catch:
- A second frame arriving while the receive-done flag is still set must leave the first byte in place. A receiver that overwrites it would lose data silently.
- A frame with a zero stop bit must be dropped. A design that skips the stop test would report corrupted bytes.
- A short low pulse on `rxd` must not start a frame. A receiver without the mid-bit start check would hang in a bogus frame and misalign the next real one.
- A one-cycle glitch at mid-bit must not change the received byte. A design that takes a single sample would flip bits.
- Two tick rates are used, so a bit period tied to the clock instead of `ovf_tick` shows up as wrong start-bit lengths.
- Buffer writes during a transmit and in the three other modes must not start a frame. A design that accepts them would produce stray frames on `txd`.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 8;

    // control register field positions
    localparam int F_MODE_HI = 7;
    localparam int F_MODE_LO = 6;
    localparam int F_REN     = 4;
    localparam int F_TDONE   = 1;
    localparam int F_RDONE   = 0;
    localparam logic [1:0] MODE_FRAME8 = 2'b01;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_st_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
endpackage

// File: rtl/sp_tick_div.sv
module sp_tick_div #(
    parameter int OVF_PER_BIT = 32,
    parameter int OVS         = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    output logic tick
);
    localparam int STEP = OVF_PER_BIT / OVS;
    localparam int CW   = (STEP > 1) ? $clog2(STEP) : 1;

    generate
        if (STEP <= 1) begin : g_pass
            assign tick = ovf;
        end else begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else if (ovf)
                    cnt <= (cnt == CW'(STEP-1)) ? '0 : cnt + CW'(1);
            end
            assign tick = ovf && (cnt == CW'(STEP-1));
        end
    endgenerate

    // R5
    tick_from_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ovf);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    output logic              txd,
    output logic              done
);
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);

    tx_st_e            st, st_n;
    logic [SW-1:0]     sub;
    logic [BW-1:0]     idx;
    logic [DATA_W-1:0] sh;
    logic              bit_end;

    assign bit_end = tick && (sub == SW'(OVS-1));

    always_comb begin
        st_n = st;
        unique case (st)
            TX_IDLE:  if (start) st_n = TX_START;
            TX_START: if (bit_end) st_n = TX_DATA;
            TX_DATA:  if (bit_end && idx == BW'(DATA_W-1)) st_n = TX_STOP;
            TX_STOP:  if (bit_end) st_n = TX_IDLE;
            default:  st_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub  <= '0;
            idx  <= '0;
            sh   <= '0;
            done <= 1'b0;
        end else begin
            done <= (st == TX_STOP) && bit_end;
            if (st == TX_IDLE && start) begin
                sh  <= din;
                sub <= '0;
                idx <= '0;
            end else if (tick && st != TX_IDLE) begin
                sub <= sub + SW'(1);
                if (bit_end && st == TX_DATA) begin
                    sh  <= sh >> 1;
                    idx <= idx + BW'(1);
                end
            end
        end
    end

    always_comb begin
        unique case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            default:  txd = 1'b1;
        endcase
    end

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE && start) |=> !txd);
    // R4
    done_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (txd && st == TX_IDLE));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              listen,
    input  logic              hold,
    output logic [DATA_W-1:0] data,
    output logic              load
);
    localparam int SW  = $clog2(OVS);
    localparam int BW  = $clog2(DATA_W);
    localparam int S_A = OVS/2 - 1;
    localparam int S_B = OVS/2;
    localparam int S_C = OVS/2 + 1;

    rx_st_e            st, st_n;
    logic [SW-1:0]     sub;
    logic [BW-1:0]     idx;
    logic [DATA_W-1:0] sh;
    logic [1:0]        smp;
    logic              s1, s2, s3;
    logic              fall, bit_end, mid_tick, maj;

    assign fall     = s3 && !s2;
    assign bit_end  = tick && (sub == SW'(OVS-1));
    assign mid_tick = tick && (sub == SW'(S_C));
    assign maj      = (smp[1] & smp[0]) | (smp[1] & s2) | (smp[0] & s2);
    assign load     = (st == RX_STOP) && mid_tick && maj && !hold;

    always_comb begin
        st_n = st;
        unique case (st)
            RX_IDLE:  if (listen && fall) st_n = RX_START;
            RX_START: if (mid_tick && maj) st_n = RX_IDLE;
                      else if (bit_end) st_n = RX_DATA;
            RX_DATA:  if (bit_end && idx == BW'(DATA_W-1)) st_n = RX_STOP;
            RX_STOP:  if (mid_tick) st_n = RX_IDLE;
            default:  st_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
            sub <= '0; idx <= '0; sh <= '0; smp <= '0;
            data <= '0;
        end else begin
            s1 <= rxd; s2 <= s1; s3 <= s2;
            if (load) data <= sh;
            if (st == RX_IDLE && listen && fall) begin
                sub <= '0;
                idx <= '0;
            end else if (tick && st != RX_IDLE) begin
                sub <= sub + SW'(1);
                if (sub == SW'(S_A) || sub == SW'(S_B))
                    smp <= {smp[0], s2};
                if (mid_tick && st == RX_DATA)
                    sh <= {maj, sh[DATA_W-1:1]};
                if (bit_end && st == RX_DATA)
                    idx <= idx + BW'(1);
            end
        end
    end

    // R8
    ren_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE && !listen) |=> st == RX_IDLE);
    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(data));
endmodule

// File: rtl/sp_serial_m1.sv
module sp_serial_m1
    import sp_pkg::*;
#(
    parameter int OVF_PER_BIT = 32,
    parameter int OVS         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_tick,
    input  logic              ctrl_wr,
    input  logic              buf_wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              rxd,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rx_data,
    output logic              txd
);
    logic tick16, tx_done, rx_load, mode_ok;

    assign mode_ok = (ctrl_q[F_MODE_HI:F_MODE_LO] == MODE_FRAME8);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata;
            if (tx_done) ctrl_q[F_TDONE] <= 1'b1;
            if (rx_load) ctrl_q[F_RDONE] <= 1'b1;
        end
    end

    sp_tick_div #(.OVF_PER_BIT(OVF_PER_BIT), .OVS(OVS)) u_div (
        .clk(clk), .rst_n(rst_n), .ovf(ovf_tick), .tick(tick16));

    sp_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .start(buf_wr && mode_ok), .din(wdata[DATA_W-1:0]),
        .txd(txd), .done(tx_done));

    sp_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .listen(mode_ok && ctrl_q[F_REN]), .hold(ctrl_q[F_RDONE]),
        .data(rx_data), .load(rx_load));

    // R6
    rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> ctrl_q[F_RDONE]);
    // R4
    tdone_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[F_TDONE]) |-> ($past(tx_done) || $past(ctrl_wr)));
endmodule

// File: tb/sim_sp_serial_m1.sv
module sim_sp_serial_m1;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovf_tick = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rxd = 1'b1;
    logic [7:0] ctrl_q, rx_data;
    logic       txd;

    int  n_chk = 0, n_bad = 0;
    int  bit_cyc = 32;
    bit  half_rate = 1'b0;
    int  phase = 0;

    sp_serial_m1 u0 (.clk(clk), .rst_n(rst_n), .ovf_tick(ovf_tick), .ctrl_wr(ctrl_wr),
        .buf_wr(buf_wr), .wdata(wdata), .rxd(rxd), .ctrl_q(ctrl_q),
        .rx_data(rx_data), .txd(txd));

    always #(CLK_NS/2) clk = ~clk;

    always @(negedge clk) begin
        phase++;
        ovf_tick = half_rate ? phase[0] : 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_wr = 1'b1; wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_buf(input logic [7:0] v);
        @(negedge clk); buf_wr = 1'b1; wdata = v;
        @(negedge clk); buf_wr = 1'b0;
    endtask

    function automatic logic [7:0] glitch_free(input logic [7:0] b);
        return b;
    endfunction

    task automatic drive_frame(input logic [7:0] b, input bit stopv, input bit glitch);
        @(negedge clk); rxd = 1'b0;
        repeat (bit_cyc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bit_cyc/2) @(negedge clk);
            if (glitch) rxd = ~rxd;
            @(negedge clk);
            rxd = b[i];
            repeat (bit_cyc/2 - 1) @(negedge clk);
        end
        rxd = stopv;
        repeat (bit_cyc) @(negedge clk);
        rxd = 1'b1;
        repeat (bit_cyc) @(negedge clk);
    endtask

    task automatic capture_tx(output logic [7:0] b, output bit found, output bit stopv);
        found = 1'b0; b = 8'h00; stopv = 1'b0;
        for (int k = 0; k < 4*bit_cyc; k++) begin
            if (txd == 1'b0) begin found = 1'b1; break; end
            @(negedge clk);
        end
        if (found) begin
            repeat (bit_cyc/2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                repeat (bit_cyc) @(negedge clk);
                b[i] = txd;
            end
            repeat (bit_cyc) @(negedge clk);
            stopv = txd;
        end
    endtask

    task automatic tx_round(input logic [7:0] v, input string req);
        logic [7:0] got; bit fnd, sv;
        wr_buf(v);
        capture_tx(got, fnd, sv);
        check(fnd && got == v && sv, req, got, v);
        repeat (bit_cyc/2 + 4) @(negedge clk);
        check(ctrl_q[1] == 1'b1, "R4 tdone set", ctrl_q[1], 1);
        wr_ctrl(8'h50);
        check(ctrl_q[1] == 1'b0, "R4 tdone cleared by write", ctrl_q[1], 0);
    endtask

    task automatic rx_round(input logic [7:0] v, input bit glitch, input string req);
        drive_frame(v, 1'b1, glitch);
        check(rx_data == glitch_free(v), req, rx_data, v);
        check(ctrl_q[0] == 1'b1, "R6 rdone set", ctrl_q[0], 1);
        wr_ctrl(8'h50);
    endtask

    task automatic start_len(input string req);
        int len = 0;
        wr_buf(8'hFF);
        while (txd == 1'b0 && len < 4*bit_cyc) begin
            @(negedge clk); len++;
        end
        check(len >= bit_cyc - 3 && len <= bit_cyc + 2, req, len, bit_cyc);
        repeat (10*bit_cyc) @(negedge clk);
        wr_ctrl(8'h50);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] b1, got;
        bit fnd, sv, low_seen;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(ctrl_q == 8'h00, "R1 ctrl reset", ctrl_q, 0);
        check(rx_data == 8'h00, "R1 rx_data reset", rx_data, 0);
        check(txd == 1'b1, "R1 txd idle", txd, 1);

        wr_ctrl(8'h50);
        check(ctrl_q == 8'h50, "R2 ctrl readback", ctrl_q, 8'h50);
        // R3 directed and random frames
        tx_round(8'h01, "R3 tx 01");
        tx_round(8'h80, "R3 tx 80");
        for (int i = 0; i < 4; i++) tx_round(8'($urandom), "R3 tx random");
        start_len("R3 start bit 32 ticks");

        // R11 write while busy
        b1 = 8'($urandom);
        wr_buf(b1);
        fork
            capture_tx(got, fnd, sv);
            begin repeat (3*bit_cyc) @(negedge clk); wr_buf(~b1); end
        join
        check(fnd && got == b1 && sv, "R11 first frame intact", got, b1);
        low_seen = 1'b0;
        repeat (3*bit_cyc) begin @(negedge clk); if (!txd) low_seen = 1'b1; end
        check(!low_seen, "R11 no second frame", low_seen, 0);
        wr_ctrl(8'h50);

        // R6 receive
        rx_round(8'h00, 1'b0, "R6 rx 00");
        rx_round(8'hFF, 1'b0, "R6 rx FF");
        for (int i = 0; i < 4; i++) rx_round(8'($urandom), 1'b0, "R6 rx random");

        // R7 overrun keeps first byte
        b1 = 8'hA5;
        drive_frame(b1, 1'b1, 1'b0);
        drive_frame(8'h3C, 1'b1, 1'b0);
        check(rx_data == b1, "R7 overrun kept", rx_data, b1);
        check(ctrl_q[0] == 1'b1, "R7 flag still set", ctrl_q[0], 1);
        wr_ctrl(8'h50);
        drive_frame(8'h5A, 1'b0, 1'b0);
        check(rx_data == b1, "R7 bad stop discarded", rx_data, b1);
        check(ctrl_q[0] == 1'b0, "R7 bad stop no flag", ctrl_q[0], 0);

        // R8 receive enable off
        wr_ctrl(8'h40);
        drive_frame(8'h66, 1'b1, 1'b0);
        check(rx_data == b1 && ctrl_q[0] == 1'b0, "R8 ignored with enable 0", rx_data, b1);
        wr_ctrl(8'h50);

        // R9 false start
        @(negedge clk); rxd = 1'b0;
        repeat (bit_cyc/4) @(negedge clk);
        rxd = 1'b1;
        repeat (12*bit_cyc) @(negedge clk);
        check(ctrl_q[0] == 1'b0 && rx_data == b1, "R9 false start no flag", ctrl_q[0], 0);
        rx_round(8'hC3, 1'b0, "R9 frame after false start");

        // R10 glitches at mid-bit
        for (int i = 0; i < 4; i++) rx_round(8'($urandom), 1'b1, "R10 majority vote");

        // R2 other modes
        for (int m = 0; m < 3; m++) begin
            logic [7:0] cv;
            cv = (m == 0) ? 8'h10 : (m == 1) ? 8'h90 : 8'hD0;
            wr_ctrl(cv);
            wr_buf(8'h00);
            low_seen = 1'b0;
            repeat (3*bit_cyc) begin @(negedge clk); if (!txd) low_seen = 1'b1; end
            check(!low_seen && ctrl_q[1] == 1'b0, "R2 no transmit in other mode", low_seen, 0);
            drive_frame(8'h99, 1'b1, 1'b0);
            check(ctrl_q[0] == 1'b0 && rx_data != 8'h99, "R2 no receive in other mode", rx_data, 0);
        end
        wr_ctrl(8'h50);

        // R5 slower overflow rate
        half_rate = 1'b1;
        bit_cyc = 64;
        repeat (8) @(negedge clk);
        start_len("R5 start bit at half rate");
        tx_round(8'($urandom), "R5 tx half rate");
        rx_round(8'($urandom), 1'b0, "R5 rx half rate");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule